// File: doc/BRIEF.md
# Interrupt Acceptance Sequencer

This block sits beside an 8-bit CPU core's instruction sequencer. It decides, at each instruction boundary, whether a non-maskable or a maskable interrupt is taken. Once it takes one, it runs the acknowledge sequence one step per clock:

- it updates the two interrupt-enable flags;
- it produces the refresh counter bumped by one;
- it pushes the 16-bit return address;
- it delivers the new program counter according to the current interrupt mode.

The core supplies the boundary strobe, the current PC, SP, refresh register, I register and a HALT indication. The core executes the memory write and read requests that the block issues. Data on the read side is taken in the same cycle as the request.

The block also reports the T-state cost of the acknowledge that it ran. The core uses this cost for its cycle accounting. The enable-interrupt and disable-interrupt strobes and the mode load come from the core's instruction decode.

Top module: `irq_accept_seq`

## Requirements
- R1: A rising edge on `nmi` is latched until taken, so a pulse that ends before the boundary is still serviced. A pending NMI wins over `int_req`. One edge is taken exactly once, and a later boundary with no new edge and no maskable request does nothing.
- R2: Taking an NMI has these effects. It clears `iff1` and leaves `iff2` unchanged. It sets `pc_out` to 0x0066, and `tstates` reads 11.
- R3: `int_req` is a level that is looked at only in the cycle that `at_boundary` is high.
    - It is ignored while `iff1` is 0.
    - A request that is withdrawn before the boundary is lost.
    - Taking it clears both `iff1` and `iff2`.
- R4: Both interrupt kinds push a return address. The return address is `pc_in`, plus one when `halted` is high. Two writes push it: first the high byte to SP-1, then the low byte to SP-2. `sp_out` then reads SP-2.
- R5: On acceptance, `r_out` keeps bit 7 of `r_in` and holds bits 6:0 incremented by one, wrapping within those 7 bits.
- R6: In mode 1, the new PC is 0x0038 and `tstates` reads 13.
- R7: In mode 0, the bus byte is taken as an opcode.
    - A restart opcode has the bit pattern 11ttt111. It vectors to ttt*8 in 13 T-states.
    - The call opcode is 0xCD. For a call, the block first raises `bus_ack` for two cycles and takes the low and then the high target byte from `bus_byte`. It pushes after that and reports 19 T-states.
- R8: In mode 0, any other bus opcode pulses `vec_err` for one cycle. No push follows, the block does not go busy, and both enable flags keep their values.
- R9: In mode 2, the block pushes and then reads the new PC. It reads the low byte from address {I, bus byte} and the high byte from that address plus one, with a 16-bit wrap. It reports 19 T-states.
- R10: After reset, `iff1` and `iff2` are 0, the block is idle and the mode is 0.
- R11: `busy` rises in the cycle after acceptance and stays high through the single cycle in which `pc_valid` is high. It falls in the next cycle, so an NMI or restart or mode-1 acknowledge is busy for 3 cycles and a call or mode-2 acknowledge for 5 cycles.
- R12: The `ei` and `di` strobes act only while the block is idle and is not accepting in that cycle: `ei` sets both flags and `di` clears both. `im_load` loads the mode from `im_sel`, where the values 2 and 3 both select mode 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| at_boundary | input | 1 | Instruction boundary strobe |
| nmi | input | 1 | Non-maskable request, rising-edge sensitive |
| int_req | input | 1 | Maskable request, level |
| bus_byte | input | 8 | Byte placed on the data bus by the interrupting device |
| i_reg | input | 8 | Interrupt page register |
| pc_in | input | 16 | Current program counter |
| sp_in | input | 16 | Current stack pointer |
| r_in | input | 8 | Current refresh register |
| halted | input | 1 | Core is sitting on a HALT instruction |
| ei | input | 1 | Enable-interrupts strobe |
| di | input | 1 | Disable-interrupts strobe |
| im_load | input | 1 | Load the interrupt mode |
| im_sel | input | 2 | Interrupt mode to load |
| mem_rdata | input | 8 | Read data for the vector-table request, same cycle |
| busy | output | 1 | Acknowledge sequence in progress |
| bus_ack | output | 1 | Taking a call operand byte from `bus_byte` this cycle |
| mem_wr | output | 1 | Stack write request |
| mem_rd | output | 1 | Vector-table read request |
| mem_addr | output | 16 | Address of the write or read request |
| mem_wdata | output | 8 | Byte to write |
| pc_valid | output | 1 | New PC, SP, R and cost are valid this cycle |
| pc_out | output | 16 | New program counter |
| sp_out | output | 16 | Stack pointer after the pushes |
| r_out | output | 8 | Refresh register after acceptance |
| tstates | output | 5 | T-state cost of the acknowledge |
| vec_err | output | 1 | Mode-0 bus opcode was neither restart nor call |
| iff1 | output | 1 | Interrupt enable flag 1 |
| iff2 | output | 1 | Interrupt enable flag 2 |

## Verification
The bench tests the following corner cases:

- An NMI pulse that ends before the boundary must still be serviced. A design that samples the level instead would drop it.
- A design that forgot to clear the latch would take the same edge twice.
- A second check combines the NMI with a live maskable request and enabled flags. A wrong priority, or an NMI that also clears `iff2`, shows up in the flags and the PC.
- A withdrawn maskable request, and one blocked by a clear `iff1`, must produce no stack traffic.
- A halted core must push PC+1. A design that ignored the HALT would return onto the HALT and sleep again.
- The mode-2 table at I=0xFF with bus byte 0xFF must wrap its second read to 0x0000.
- A bad mode-0 opcode must raise only the error pulse.

Random trials across all modes also compare the push order, operand order and T-state costs.

// File: rtl/irq_accept_pkg.sv
package irq_accept_pkg;
    localparam int BYTE_W = 8;
    localparam int ADDR_W = 2 * BYTE_W;
    localparam int COST_W = 5;

    typedef enum logic [2:0] {
        ST_IDLE, ST_OPLO, ST_OPHI, ST_PUSHH, ST_PUSHL, ST_TBLLO, ST_TBLHI, ST_DONE
    } step_e;

    typedef enum logic [2:0] {
        K_NMI, K_RST, K_CALL, K_M1, K_M2
    } kind_e;

    // T-state cost of each acknowledge flavour
    function automatic logic [COST_W-1:0] cost_of(kind_e k);
        case (k)
            K_NMI:          return COST_W'(11);
            K_RST, K_M1:    return COST_W'(13);
            default:        return COST_W'(19);
        endcase
    endfunction
endpackage

// File: rtl/irq_nmi_latch.sv
module irq_nmi_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic nmi,
    input  logic take,
    output logic pending
);
    typedef struct packed {
        logic prev;
        logic pend;
    } edge_t;

    edge_t d, q;

    always_comb begin
        d      = q;
        d.prev = nmi;
        // a new edge in the cycle of a take survives as a fresh request
        d.pend = (q.pend & ~take) | (nmi & ~q.prev);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign pending = q.pend;

    AST_NMI_EDGE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (nmi && !q.prev) |=> pending); // R1
endmodule

// File: rtl/irq_m0_decode.sv
module irq_m0_decode
    import irq_accept_pkg::*;
(
    input  logic [BYTE_W-1:0] opcode,
    output logic              is_rst,
    output logic              is_call,
    output logic [ADDR_W-1:0] rst_tgt
);
    localparam logic [BYTE_W-1:0] CALL_OP = 8'hCD;

    always_comb begin
        is_rst       = (opcode[7:6] == 2'b11) && (opcode[2:0] == 3'b111);
        is_call      = (opcode == CALL_OP);
        rst_tgt      = '0;
        rst_tgt[5:3] = opcode[5:3];
    end
endmodule

// File: rtl/irq_accept_seq.sv
module irq_accept_seq
    import irq_accept_pkg::*;
#(
    parameter logic [15:0] NMI_VEC = 16'h0066,
    parameter logic [15:0] M1_VEC  = 16'h0038
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              at_boundary,
    input  logic              nmi,
    input  logic              int_req,
    input  logic [7:0]        bus_byte,
    input  logic [7:0]        i_reg,
    input  logic [15:0]       pc_in,
    input  logic [15:0]       sp_in,
    input  logic [7:0]        r_in,
    input  logic              halted,
    input  logic              ei,
    input  logic              di,
    input  logic              im_load,
    input  logic [1:0]        im_sel,
    input  logic [7:0]        mem_rdata,
    output logic              busy,
    output logic              bus_ack,
    output logic              mem_wr,
    output logic              mem_rd,
    output logic [15:0]       mem_addr,
    output logic [7:0]        mem_wdata,
    output logic              pc_valid,
    output logic [15:0]       pc_out,
    output logic [15:0]       sp_out,
    output logic [7:0]        r_out,
    output logic [4:0]        tstates,
    output logic              vec_err,
    output logic              iff1,
    output logic              iff2
);
    typedef struct packed {
        step_e             step;
        kind_e             kind;
        logic [ADDR_W-1:0] tgt;
        logic [ADDR_W-1:0] tbl;
        logic [ADDR_W-1:0] sp;
        logic [ADDR_W-1:0] ret;
        logic [BYTE_W-1:0] r;
        logic              iff1;
        logic              iff2;
        logic [1:0]        im;
        logic              err;
    } seq_t;

    seq_t d, q;
    logic nmi_pend, take_nmi, accept;
    logic is_rst, is_call;
    logic [ADDR_W-1:0] rst_tgt;

    irq_nmi_latch u_nmi (
        .clk(clk), .rst_n(rst_n), .nmi(nmi), .take(take_nmi), .pending(nmi_pend)
    );

    irq_m0_decode u_dec (
        .opcode(bus_byte), .is_rst(is_rst), .is_call(is_call), .rst_tgt(rst_tgt)
    );

    always_comb begin
        d        = q;
        d.err    = 1'b0;
        take_nmi = 1'b0;
        accept   = 1'b0;
        if (im_load) d.im = im_sel;
        unique case (q.step)
            ST_IDLE: begin
                if (at_boundary && nmi_pend) begin
                    take_nmi = 1'b1;
                    accept   = 1'b1;
                    d.kind   = K_NMI;
                    d.tgt    = NMI_VEC;
                    d.iff1   = 1'b0;
                    d.step   = ST_PUSHH;
                end else if (at_boundary && int_req && q.iff1) begin
                    if (q.im == 2'd0) begin
                        if (is_rst) begin
                            accept = 1'b1;
                            d.kind = K_RST;
                            d.tgt  = rst_tgt;
                            d.step = ST_PUSHH;
                        end else if (is_call) begin
                            accept = 1'b1;
                            d.kind = K_CALL;
                            d.step = ST_OPLO;
                        end else begin
                            d.err = 1'b1;
                        end
                    end else if (q.im == 2'd1) begin
                        accept = 1'b1;
                        d.kind = K_M1;
                        d.tgt  = M1_VEC;
                        d.step = ST_PUSHH;
                    end else begin
                        accept = 1'b1;
                        d.kind = K_M2;
                        d.tbl  = {i_reg, bus_byte};
                        d.step = ST_PUSHH;
                    end
                    if (accept) begin
                        d.iff1 = 1'b0;
                        d.iff2 = 1'b0;
                    end
                end else if (ei) begin
                    d.iff1 = 1'b1;
                    d.iff2 = 1'b1;
                end else if (di) begin
                    d.iff1 = 1'b0;
                    d.iff2 = 1'b0;
                end
                if (accept) begin
                    d.ret = pc_in + ADDR_W'(halted);
                    d.sp  = sp_in;
                    d.r   = {r_in[BYTE_W-1], r_in[BYTE_W-2:0] + 1'b1};
                end
            end
            ST_OPLO: begin
                d.tgt[BYTE_W-1:0] = bus_byte;
                d.step            = ST_OPHI;
            end
            ST_OPHI: begin
                d.tgt[ADDR_W-1:BYTE_W] = bus_byte;
                d.step                 = ST_PUSHH;
            end
            ST_PUSHH: d.step = ST_PUSHL;
            ST_PUSHL: d.step = (q.kind == K_M2) ? ST_TBLLO : ST_DONE;
            ST_TBLLO: begin
                d.tgt[BYTE_W-1:0] = mem_rdata;
                d.step            = ST_TBLHI;
            end
            ST_TBLHI: begin
                d.tgt[ADDR_W-1:BYTE_W] = mem_rdata;
                d.step                 = ST_DONE;
            end
            ST_DONE:  d.step = ST_IDLE;
            default:  d.step = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.step <= ST_IDLE;
            q.kind <= K_NMI;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        busy      = (q.step != ST_IDLE);
        bus_ack   = (q.step == ST_OPLO) || (q.step == ST_OPHI);
        mem_wr    = (q.step == ST_PUSHH) || (q.step == ST_PUSHL);
        mem_rd    = (q.step == ST_TBLLO) || (q.step == ST_TBLHI);
        mem_wdata = (q.step == ST_PUSHH) ? q.ret[ADDR_W-1:BYTE_W] : q.ret[BYTE_W-1:0];
        unique case (q.step)
            ST_PUSHH: mem_addr = q.sp - ADDR_W'(1);
            ST_PUSHL: mem_addr = q.sp - ADDR_W'(2);
            ST_TBLHI: mem_addr = q.tbl + ADDR_W'(1);
            default:  mem_addr = q.tbl;
        endcase
        pc_valid = (q.step == ST_DONE);
        pc_out   = q.tgt;
        sp_out   = q.sp - ADDR_W'(2);
        r_out    = q.r;
        tstates  = cost_of(q.kind);
        vec_err  = q.err;
        iff1     = q.iff1;
        iff2     = q.iff2;
    end

    AST_NMI_KEEPS_IFF2: assert property (@(posedge clk) disable iff (!rst_n)
        (q.step == ST_IDLE && at_boundary && nmi_pend) |=> (!iff1 && iff2 == $past(iff2))); // R2
    AST_INT_NEEDS_IFF1: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(busy) && q.kind != K_NMI) |-> ($past(iff1) && !iff1 && !iff2)); // R3
    AST_PUSH_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr && mem_addr == q.sp - ADDR_W'(1)) |=> (mem_wr && mem_addr == $past(mem_addr) - ADDR_W'(1))); // R4
    AST_TBL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd && mem_addr == q.tbl) |=> (mem_rd && mem_addr == $past(mem_addr) + ADDR_W'(1))); // R9
    AST_DONE_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        pc_valid |=> !busy); // R11
    AST_ERR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        vec_err |-> (!busy && $stable(iff1) && $stable(iff2))); // R8
    AST_COST_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        pc_valid |-> (tstates == 5'd11 || tstates == 5'd13 || tstates == 5'd19)); // R7
endmodule

// File: tb/test_irq_accept_seq.sv
module test_irq_accept_seq;
    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst_n = 1'b0, at_boundary = 1'b0, nmi = 1'b0, int_req = 1'b0, halted = 1'b0;
    logic ei = 1'b0, di = 1'b0, im_load = 1'b0;
    logic [1:0]  im_sel = '0;
    logic [7:0]  bus_byte = '0, i_reg = '0, r_in = '0, mem_rdata = '0;
    logic [15:0] pc_in = '0, sp_in = '0;
    logic busy, bus_ack, mem_wr, mem_rd, pc_valid, vec_err, iff1, iff2;
    logic [15:0] mem_addr, pc_out, sp_out;
    logic [7:0]  mem_wdata, r_out;
    logic [4:0]  tstates;

    irq_accept_seq i_irq_accept_seq (.*);

    int checks = 0, fails = 0;
    bit m_iff1 = 0, m_iff2 = 0, m_pend = 0;
    logic [1:0] m_im = 2'd0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] mem_model(input logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ 8'hA5;
    endfunction

    task automatic trial(input bit ld_im, input logic [1:0] im, input bit do_en, input bit en,
                         input bit do_nmi, input bit intl, input logic [7:0] vb, input bit hlt,
                         input logic [15:0] pcv, input logic [15:0] spv, input logic [7:0] rv,
                         input logic [7:0] iv, input logic [7:0] oplo, input logic [7:0] ophi);
        int kind, bc, wc, rc, ac, ec, pv, ex_bc;
        logic [15:0] wa[2], ra[2], ret, ex_pc, t, pc_c, sp_c, e1, e2;
        logic [7:0] wd[2], r_c;
        logic [4:0] ts_c, ex_ts;
        bit rs, cl;
        string tag;
        bc = 0; wc = 0; rc = 0; ac = 0; ec = 0; pv = 0;
        pc_c = '0; sp_c = '0; r_c = '0; ts_c = '0;
        @(negedge clk);
        if (ld_im) begin im_load = 1'b1; im_sel = im; m_im = im; end
        if (do_en) begin ei = en; di = !en; m_iff1 = en; m_iff2 = en; end
        @(negedge clk);
        im_load = 1'b0; ei = 1'b0; di = 1'b0;
        if (do_nmi) begin nmi = 1'b1; @(negedge clk); nmi = 1'b0; m_pend = 1; end
        int_req = intl; bus_byte = vb; halted = hlt; pc_in = pcv; sp_in = spv; r_in = rv; i_reg = iv;
        @(negedge clk);
        at_boundary = 1'b1;
        // expected outcome from the requirements
        rs = (vb[7:6] == 2'b11) && (vb[2:0] == 3'b111);
        cl = (vb == 8'hCD);
        ret = pcv + {15'd0, hlt};
        t = {iv, vb};
        ex_pc = '0; ex_ts = '0; ex_bc = 3; tag = "R12";
        if (m_pend) begin
            kind = 1; ex_pc = 16'h0066; ex_ts = 5'd11; tag = "R2";
        end else if (intl && m_iff1) begin
            if (m_im == 2'd0 && !rs && !cl) kind = 3;
            else begin
                kind = 2;
                if (m_im == 2'd0 && rs) begin ex_pc = {10'd0, vb[5:3], 3'd0}; ex_ts = 5'd13; tag = "R7"; end
                else if (m_im == 2'd0) begin ex_pc = {ophi, oplo}; ex_ts = 5'd19; ex_bc = 5; tag = "R7"; end
                else if (m_im == 2'd1) begin ex_pc = 16'h0038; ex_ts = 5'd13; tag = "R6"; end
                else begin
                    e1 = t + 16'd1;
                    ex_pc = {mem_model(e1), mem_model(t)}; ex_ts = 5'd19; ex_bc = 5; tag = "R9";
                end
            end
        end else kind = 0;
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            if (k == 0) at_boundary = 1'b0;
            if (busy) bc++;
            if (mem_wr) begin if (wc < 2) begin wa[wc] = mem_addr; wd[wc] = mem_wdata; end wc++; end
            if (mem_rd) begin if (rc < 2) ra[rc] = mem_addr; mem_rdata = mem_model(mem_addr); rc++; end
            if (bus_ack) begin bus_byte = (ac == 0) ? oplo : ophi; ac++; end
            if (vec_err) ec++;
            if (pc_valid) begin pv++; pc_c = pc_out; sp_c = sp_out; r_c = r_out; ts_c = tstates; end
        end
        int_req = 1'b0;
        if (kind == 0) begin
            chk(bc == 0 && wc == 0 && pv == 0, intl ? "R3 no take" : "R1 no take", bc, 0);
        end else if (kind == 3) begin
            chk(ec == 1 && bc == 0 && wc == 0, "R8 bad opcode", {ec[15:0], bc[15:0]}, 32'h10000);
        end else begin
            e1 = spv - 16'd1; e2 = spv - 16'd2;
            chk(pv == 1 && bc == ex_bc, "R11 busy span", bc, ex_bc);
            chk(pc_c == ex_pc, tag, pc_c, ex_pc);
            chk(ts_c == ex_ts, tag, ts_c, ex_ts);
            chk(wc == 2 && wa[0] == e1 && wd[0] == ret[15:8], "R4 push high", {wa[0], wd[0]}, {e1, ret[15:8]});
            chk(wa[1] == e2 && wd[1] == ret[7:0], "R4 push low", {wa[1], wd[1]}, {e2, ret[7:0]});
            chk(sp_c == e2, "R4 sp", sp_c, e2);
            chk(r_c == {rv[7], rv[6:0] + 7'd1}, "R5 refresh", r_c, {rv[7], rv[6:0] + 7'd1});
            if (ex_bc == 5 && m_im == 2'd0 && kind == 2)
                chk(ac == 2 && rc == 0, "R7 call operands", ac, 2);
            if (kind == 2 && m_im >= 2'd2) begin
                e1 = t + 16'd1;
                chk(rc == 2 && ra[0] == t && ra[1] == e1, "R9 table", {ra[0], ra[1]}, {t, e1});
            end
            if (kind == 1) begin m_iff1 = 0; m_pend = 0; end
            else begin m_iff1 = 0; m_iff2 = 0; end
        end
        chk(iff1 == m_iff1 && iff2 == m_iff2, (kind == 1) ? "R2 flags" : (kind == 2) ? "R3 flags" : "R12 flags",
            {iff1, iff2}, {m_iff1, m_iff2});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", checks, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !iff1 && !iff2 && !vec_err && !mem_wr, "R10 reset state", {busy, iff1, iff2}, 0);
        // R10: mode 0 after reset, restart 0xFF goes to 0x0038
        trial(0, 2'd0, 1, 1, 0, 1, 8'hFF, 0, 16'h1234, 16'h8000, 8'h7F, 8'h00, 8'h00, 8'h00);
        // R2: NMI keeps iff2
        trial(0, 2'd0, 1, 1, 1, 0, 8'h00, 0, 16'h0100, 16'h0000, 8'hFF, 8'h00, 8'h00, 8'h00);
        // R1: NMI wins over a live INT, then no repeat
        trial(1, 2'd1, 1, 1, 1, 1, 8'h00, 0, 16'h2000, 16'h4000, 8'h80, 8'h00, 8'h00, 8'h00);
        trial(0, 2'd1, 0, 0, 0, 0, 8'h00, 0, 16'h2000, 16'h4000, 8'h00, 8'h00, 8'h00, 8'h00);
        // R3: INT blocked by clear iff1
        trial(1, 2'd1, 1, 0, 0, 1, 8'hFF, 0, 16'h3000, 16'h5000, 8'h00, 8'h00, 8'h00, 8'h00);
        // R3: INT withdrawn before the boundary is lost
        @(negedge clk); ei = 1'b1; m_iff1 = 1; m_iff2 = 1;
        @(negedge clk); ei = 1'b0; int_req = 1'b1;
        repeat (3) @(negedge clk);
        int_req = 1'b0;
        trial(0, 2'd1, 0, 0, 0, 0, 8'h00, 0, 16'h3000, 16'h5000, 8'h00, 8'h00, 8'h00, 8'h00);
        // R8: bad mode-0 opcode
        trial(1, 2'd0, 1, 1, 0, 1, 8'h00, 0, 16'h3000, 16'h5000, 8'h00, 8'h00, 8'h00, 8'h00);
        // R9: table wrap at 0xFFFF, R4: halted pushes PC+1
        trial(1, 2'd2, 1, 1, 0, 1, 8'hFF, 1, 16'hFFFF, 16'h0001, 8'h12, 8'hFF, 8'h00, 8'h00);
        // R7: call in mode 0
        trial(1, 2'd0, 1, 1, 0, 1, 8'hCD, 0, 16'hABCD, 16'hC000, 8'h05, 8'h00, 8'h34, 8'h12);
        for (int n = 0; n < 300; n++) begin
            logic [7:0] vb;
            int sel;
            sel = int'($urandom % 4);
            vb = (sel == 0) ? (8'($urandom) | 8'hC7) : (sel == 1) ? 8'hCD : 8'($urandom);
            trial(1, 2'($urandom), 1, 1'($urandom), ($urandom % 4) == 0, 1'($urandom), vb, 1'($urandom),
                  16'($urandom), 16'($urandom), 8'($urandom), 8'($urandom), 8'($urandom), 8'($urandom));
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule